// File: doc/BRIEF.md
# Aliased Execute-in-Place Flash Cache

This block serves 32-bit reads for code that runs directly from a quad-SPI serial flash. A read arrives on a valid/ready port. The top byte of its address picks one of three windows onto the same 24-bit flash space, and each window carries its own caching policy. Window 0x10 looks up the cache and fills the line on a miss. Window 0x11 looks up the cache but does not fill on a miss. Window 0x13 skips the cache and always goes to the flash. Any other top byte gets an error response and leaves the flash untouched.

The cache holds 16 KB of data. It is direct-mapped with one 32-bit word per line, and each line has a valid bit and a tag. A single-cycle flush pulse clears every valid bit at once.

On a miss or a bypass, a serial engine sends a complete read transfer to the flash: command, full address, dummy clocks and data. It does this every time, with no continuous-read shortcut. The serial clock runs at one quarter of the system clock, so a fetched word costs 80 system cycles.

A controller state machine sequences each read through four states. IDLE waits for a request. LOOKUP decodes the window and checks the line. FETCH waits for the serial engine. RESP presents the registered response for one cycle. The transitions are:
- IDLE→LOOKUP when a request is accepted.
- LOOKUP→RESP on a bad window, or on a hit in a cached window.
- LOOKUP→FETCH otherwise.
- FETCH→RESP when the engine signals completion. A fill happens here for window 0x10.
- RESP→IDLE unconditionally.

Top module: `xip_alias_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `qspi_cs_n` is 1 and `qspi_sck` is 0.
- R2: A read with top byte 0x10 that misses fetches the word from the flash and fills its line. A repeat of the same address is then a hit, with no flash transfer.
- R3: A read with top byte 0x11 returns cached data on a hit. On a miss it fetches from the flash without filling, so repeating the read, or reading the same address through window 0x10, fetches again.
- R4: A read with top byte 0x13 always fetches from the flash, even when the line holds the word.
- R5: A read with any other top byte returns `rsp_err`=1 and `rsp_data`=0, with no flash transfer, on the edge after acceptance.
- R6: Each fetch holds `qspi_cs_n` low for exactly 20 rising edges of `qspi_sck`, and the lines are sampled at those rising edges:
  - Edges 1–2 carry the command 0xEB, high nibble first, with `qspi_io_oe`=4'hF.
  - Edges 3–8 carry the 24-bit flash address, most significant nibble first. This is `req_addr[23:0]` with its two low bits forced to 0, and `qspi_io_oe`=4'hF.
  - Edges 9–20 have `qspi_io_oe`=0: four dummy clocks, then eight data clocks.
- R7: `qspi_sck` is the system clock divided by four (two cycles high, two low). A fetched response appears on the 82nd clock edge after acceptance. A hit appears on the first edge after acceptance.
- R8: The eight data nibbles are read most significant first, pairwise, as bytes in address order. Byte k of the transfer lands in `rsp_data[8k+7:8k]`, the little-endian order.
- R9: A one-cycle `flush` pulse invalidates every line, so the next window 0x10 read of a previously filled address fetches again.
- R10: Lines are indexed by `req_addr[13:2]` and tagged by `req_addr[23:14]`. Two addresses that share an index but differ in tag evict each other. All windows share the same lines.
- R11: `rsp_valid` is a one-cycle pulse, and `req_ready` stays low from the acceptance edge until the response cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Read address; top byte selects the window |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_data | output | 32 | Read data |
| rsp_err | output | 1 | Unmapped window |
| qspi_sck | output | 1 | Serial clock |
| qspi_cs_n | output | 1 | Flash select, active low |
| qspi_io_o | output | 4 | Data lines driven toward the flash |
| qspi_io_oe | output | 4 | Output enable per data line |
| qspi_io_i | input | 4 | Data lines read from the flash |

## Verification
The checker assumes that `rst_n` is applied before the first request. It also assumes that `qspi_io_i` is stable around the system edge at which the engine samples it, which is the last high cycle of each serial clock. The bench's flash model only changes the data lines on a falling serial clock, which keeps them well inside that window. Requests are presented only while `req_ready` is high and are withdrawn right after acceptance. The flush pulse is issued only while the block is idle, so no assertion has to reason about a fill racing an invalidate.

// File: rtl/xac_pkg.sv
package xac_pkg;

    localparam int FLASH_AW = 24;
    localparam logic [7:0] RD_CMD = 8'hEB;

    // Serial transfer layout in quad clocks
    localparam int CMD_CLKS   = 2;
    localparam int ADDR_CLKS  = 6;
    localparam int DUMMY_CLKS = 4;
    localparam int DATA_CLKS  = 8;
    localparam int DRIVE_END  = CMD_CLKS + ADDR_CLKS;
    localparam int DATA_START = DRIVE_END + DUMMY_CLKS;
    localparam int FRAME_CLKS = DATA_START + DATA_CLKS;

    localparam logic [7:0] WIN_ALLOC   = 8'h10;
    localparam logic [7:0] WIN_NOALLOC = 8'h11;
    localparam logic [7:0] WIN_DIRECT  = 8'h13;

    typedef enum logic [1:0] {
        POL_ALLOC,
        POL_NOALLOC,
        POL_DIRECT,
        POL_INVALID
    } policy_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FETCH,
        ST_RESP
    } ctl_state_e;

    function automatic policy_e decode_window(input logic [7:0] top);
        policy_e p;
        case (top)
            WIN_ALLOC:   p = POL_ALLOC;
            WIN_NOALLOC: p = POL_NOALLOC;
            WIN_DIRECT:  p = POL_DIRECT;
            default:     p = POL_INVALID;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/xac_line_store.sv
module xac_line_store #(
    parameter int LINES = 4096,
    parameter int IDX_W = 12,
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    output logic [31:0]      rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [31:0]      wr_data
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_mem  [LINES];
    logic [31:0]      data_mem [LINES];

    // Flush wins over a same-cycle fill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            valid_q <= '0;
        else if (flush)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    assign hit     = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
    assign rd_data = data_mem[rd_idx];

endmodule

// File: rtl/xac_qspi_fetch.sv
module xac_qspi_fetch
    import xac_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [FLASH_AW-1:0] addr,
    output logic                done,
    output logic [31:0]         word,
    output logic                sck,
    output logic                cs_n,
    output logic [3:0]          io_o,
    output logic [3:0]          io_oe,
    input  logic [3:0]          io_i
);

    localparam int CI_W = $clog2(FRAME_CLKS);
    localparam logic [CI_W-1:0] LAST_CLK   = CI_W'(FRAME_CLKS - 1);
    localparam logic [CI_W-1:0] FIRST_DATA = CI_W'(DATA_START);
    localparam logic [CI_W-1:0] CMD_END    = CI_W'(CMD_CLKS);
    localparam logic [CI_W-1:0] DRV_END    = CI_W'(DRIVE_END);

    logic                busy_q;
    logic                done_q;
    logic [CI_W-1:0]     clk_idx;
    logic [1:0]          ph;
    logic [FLASH_AW-1:0] addr_q;
    logic [31:0]         word_q;
    logic [CI_W-1:0]     nib;
    logic [CI_W-1:0]     a_off;
    logic [4:0]          nib_pos;
    logic [FLASH_AW-1:0] addr_sh;

    // Byte k of the stream fills bits [8k+7:8k]; high nibble first
    assign nib     = clk_idx - FIRST_DATA;
    assign nib_pos = {nib[2:1], ~nib[0], 2'b00};
    assign a_off   = clk_idx - CMD_END;
    assign addr_sh = addr_q << {a_off, 2'b00};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            clk_idx <= '0;
            ph      <= '0;
            addr_q  <= '0;
            word_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q  <= 1'b1;
                    clk_idx <= '0;
                    ph      <= '0;
                    addr_q  <= addr;
                    word_q  <= '0;
                end
            end else begin
                ph <= ph + 2'd1;
                if (ph == 2'd3) begin
                    if (clk_idx >= FIRST_DATA)
                        word_q[nib_pos +: 4] <= io_i;
                    if (clk_idx == LAST_CLK) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        clk_idx <= clk_idx + 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        io_o = 4'h0;
        if (busy_q) begin
            if (clk_idx < CMD_END)
                io_o = clk_idx[0] ? RD_CMD[3:0] : RD_CMD[7:4];
            else if (clk_idx < DRV_END)
                io_o = addr_sh[FLASH_AW-1 -: 4];
        end
    end

    assign io_oe = (busy_q && clk_idx < DRV_END) ? 4'hF : 4'h0;
    assign sck   = busy_q & ph[1];
    assign cs_n  = ~busy_q;
    assign done  = done_q;
    assign word  = word_q;

endmodule

// File: rtl/xip_alias_cache.sv
module xip_alias_cache
    import xac_pkg::*;
#(
    parameter int CACHE_BYTES = 16384
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic        rsp_err,
    output logic        qspi_sck,
    output logic        qspi_cs_n,
    output logic [3:0]  qspi_io_o,
    output logic [3:0]  qspi_io_oe,
    input  logic [3:0]  qspi_io_i
);

    localparam int LINES = CACHE_BYTES / 4;
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = FLASH_AW - 2 - IDX_W;

    ctl_state_e  st_q, st_d;
    logic [31:0] addr_q;
    policy_e     pol;
    logic        cached_pol;
    logic        hit;
    logic [31:0] line_data;
    logic        fetch_start;
    logic        fetch_done;
    logic [31:0] fetch_word;
    logic        fill_en;
    logic [31:0] rsp_data_q;
    logic        rsp_err_q;
    logic [IDX_W-1:0] line_idx;
    logic [TAG_W-1:0] line_tag;

    assign pol        = decode_window(addr_q[31:24]);
    assign cached_pol = (pol == POL_ALLOC) || (pol == POL_NOALLOC);
    assign line_idx   = addr_q[IDX_W+1:2];
    assign line_tag   = addr_q[FLASH_AW-1:IDX_W+2];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && req_valid)
                addr_q <= req_addr;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (req_valid) st_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (pol == POL_INVALID || (cached_pol && hit))
                    st_d = ST_RESP;
                else
                    st_d = ST_FETCH;
            end
            ST_FETCH:  if (fetch_done) st_d = ST_RESP;
            ST_RESP:   st_d = ST_IDLE;
        endcase
    end

    assign fetch_start = (st_q == ST_LOOKUP) && (st_d == ST_FETCH);
    assign fill_en     = (st_q == ST_FETCH) && fetch_done && (pol == POL_ALLOC);

    // Registered response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_data_q <= '0;
            rsp_err_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_LOOKUP: begin
                    if (pol == POL_INVALID) begin
                        rsp_data_q <= '0;
                        rsp_err_q  <= 1'b1;
                    end else if (cached_pol && hit) begin
                        rsp_data_q <= line_data;
                        rsp_err_q  <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) begin
                        rsp_data_q <= fetch_word;
                        rsp_err_q  <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign req_ready = (st_q == ST_IDLE);
    assign rsp_valid = (st_q == ST_RESP);
    assign rsp_data  = rsp_data_q;
    assign rsp_err   = rsp_err_q;

    xac_line_store #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .rd_idx  (line_idx),
        .rd_tag  (line_tag),
        .hit     (hit),
        .rd_data (line_data),
        .wr_en   (fill_en),
        .wr_idx  (line_idx),
        .wr_tag  (line_tag),
        .wr_data (fetch_word)
    );

    xac_qspi_fetch u_fetch (
        .clk   (clk),
        .rst_n (rst_n),
        .start (fetch_start),
        .addr  ({addr_q[FLASH_AW-1:2], 2'b00}),
        .done  (fetch_done),
        .word  (fetch_word),
        .sck   (qspi_sck),
        .cs_n  (qspi_cs_n),
        .io_o  (qspi_io_o),
        .io_oe (qspi_io_oe),
        .io_i  (qspi_io_i)
    );

endmodule

// File: rtl/xac_checker.sv
module xac_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [31:0] rsp_data,
    input logic        rsp_err,
    input logic        qspi_sck,
    input logic        qspi_cs_n,
    input logic [3:0]  qspi_io_oe
);

    p_select_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !qspi_cs_n |-> !req_ready);

    p_sck_framed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        qspi_cs_n |-> !qspi_sck);

    p_lines_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        qspi_cs_n |-> (qspi_io_oe == 4'h0));

    p_sck_high_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qspi_sck) |=> qspi_sck);

    p_sck_low_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(qspi_sck) |=> !qspi_sck);

    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_accept_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_err_no_flash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ($past(qspi_cs_n) && rsp_data == 32'h0));

endmodule

bind xip_alias_cache xac_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_err    (rsp_err),
    .qspi_sck   (qspi_sck),
    .qspi_cs_n  (qspi_cs_n),
    .qspi_io_oe (qspi_io_oe)
);

// File: tb/xip_alias_cache_test.sv
module xip_alias_cache_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = 32'h0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_err;
    logic        qspi_sck;
    logic        qspi_cs_n;
    logic [3:0]  qspi_io_o;
    logic [3:0]  qspi_io_oe;
    logic [3:0]  qspi_io_i = 4'h0;

    always #4 clk = ~clk;

    xip_alias_cache uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .qspi_sck(qspi_sck), .qspi_cs_n(qspi_cs_n),
        .qspi_io_o(qspi_io_o), .qspi_io_oe(qspi_io_oe), .qspi_io_i(qspi_io_i)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Flash model
    int          frames = 0;
    int          nclk = 0;
    int          rises = 0;
    bit          oe_bad = 0;
    logic [7:0]  cap_cmd = 8'h0;
    logic [23:0] cap_addr = 24'h0;

    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] fword(input logic [23:0] a);
        logic [23:0] b;
        b = {a[23:2], 2'b00};
        return {fbyte(b + 24'd3), fbyte(b + 24'd2), fbyte(b + 24'd1), fbyte(b)};
    endfunction

    always @(negedge qspi_cs_n) begin
        frames++;
        nclk = 0;
        rises = 0;
        oe_bad = 0;
        cap_cmd = 8'h0;
        cap_addr = 24'h0;
    end

    always @(posedge qspi_sck) begin
        if (nclk < 2) cap_cmd = {cap_cmd[3:0], qspi_io_o};
        else if (nclk < 8) cap_addr = {cap_addr[19:0], qspi_io_o};
        if (nclk < 8 && qspi_io_oe != 4'hF) oe_bad = 1;
        if (nclk >= 8 && qspi_io_oe != 4'h0) oe_bad = 1;
        nclk++;
        rises++;
    end

    always @(negedge qspi_sck) begin : drive_data
        int j;
        logic [7:0] b;
        if (nclk >= 12 && nclk <= 19) begin
            j = nclk - 12;
            b = fbyte(cap_addr + 24'(j / 2));
            qspi_io_i = (j % 2 == 0) ? b[7:4] : b[3:0];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [31:0] a, output logic [31:0] d, output logic e,
                           output int lat, output bit rdy_mid);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        lat = 0;
        rdy_mid = 0;
        @(negedge clk);
        req_valid = 1'b0;
        while (lat < 500) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (rsp_valid) break;
            if (req_ready) rdy_mid = 1;
        end
        d = rsp_data;
        e = rsp_err;
        @(posedge clk);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R11 pulse/ready after response",
            {30'h0, rsp_valid, req_ready}, 32'h1);
        chk(!rdy_mid, "R11 ready low while busy", {31'h0, rdy_mid}, 32'h0);
    endtask

    // Read and check data, latency and number of flash transfers
    task automatic read_expect(input logic [31:0] a, input bit fetch, input string tag);
        logic [31:0] d;
        logic e;
        int lat;
        bit rm;
        int f0;
        f0 = frames;
        do_read(a, d, e, lat, rm);
        chk(d == fword(a[23:0]) && !e, {tag, " data"}, d, fword(a[23:0]));
        chk(lat == (fetch ? 82 : 1), {tag, " latency R7"}, lat, fetch ? 82 : 1);
        chk(frames - f0 == (fetch ? 1 : 0), {tag, " flash transfers"}, frames - f0, fetch ? 1 : 0);
    endtask

    task automatic check_frame(input logic [31:0] a, input string tag);
        chk(cap_cmd == 8'hEB, {tag, " R6 command"}, cap_cmd, 8'hEB);
        chk(cap_addr == {a[23:2], 2'b00}, {tag, " R6 address"}, cap_addr, {a[23:2], 2'b00});
        chk(rises == 20, {tag, " R6 clock count"}, rises, 20);
        chk(!oe_bad, {tag, " R6 line direction"}, oe_bad, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req_ready && !rsp_valid && qspi_cs_n && !qspi_sck, "R1 reset state",
            {28'h0, req_ready, rsp_valid, qspi_cs_n, qspi_sck}, 32'hA);
    endtask

    task automatic t_alloc;
        read_expect(32'h1000_0040, 1, "R2 alloc miss");
        check_frame(32'h1000_0040, "R2");
        read_expect(32'h1000_0040, 0, "R2 alloc hit");
        read_expect(32'h10AB_CD10, 1, "R8 assembly pattern");
        check_frame(32'h10AB_CD10, "R8");
    endtask

    task automatic t_noalloc;
        read_expect(32'h1100_0040, 0, "R3 noalloc hit");
        read_expect(32'h1100_0080, 1, "R3 noalloc miss");
        read_expect(32'h1100_0080, 1, "R3 noalloc repeat");
        read_expect(32'h1000_0080, 1, "R3 line not filled");
    endtask

    task automatic t_direct;
        read_expect(32'h1300_0040, 1, "R4 bypass cached line");
        read_expect(32'h1300_0207, 1, "R6 unaligned bypass");
        check_frame(32'h1300_0207, "R6 unaligned");
    endtask

    task automatic t_invalid;
        logic [31:0] d;
        logic e;
        int lat;
        bit rm;
        int f0;
        logic [31:0] bad [3] = '{32'h2200_0040, 32'h1200_0040, 32'h0000_0040};
        for (int i = 0; i < 3; i++) begin
            f0 = frames;
            do_read(bad[i], d, e, lat, rm);
            chk(e && d == 0, "R5 error response", {d[30:0], e}, 32'h1);
            chk(lat == 1 && frames == f0, "R5 no flash, one edge", lat, 1);
        end
    endtask

    task automatic t_flush;
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        read_expect(32'h1000_0040, 1, "R9 miss after flush");
        read_expect(32'h1000_0040, 0, "R9 refilled hit");
    endtask

    task automatic t_conflict;
        read_expect(32'h1000_4040, 1, "R10 same index new tag");
        read_expect(32'h1100_4040, 0, "R10 shared line via 0x11");
        read_expect(32'h1000_0040, 1, "R10 evicted original");
        read_expect(32'h1100_4040, 1, "R10 evicted other");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R11 actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_alloc();
        t_noalloc();
        t_direct();
        t_invalid();
        t_flush();
        t_conflict();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule